// File: doc/BRIEF.md
# Timed Flash Self-Programming Command Register

This block is the control and status register that software uses to drive program-memory self-programming. A byte-wide write to the register arms a store command for a short window. The low five bits of the write select the action: a word store into the temporary page buffer, a page erase, a page write, a lock-bit set, or a re-enable of the read section. When the store instruction executes inside that window, its strobe fires the action. The action either writes the page buffer or sends a one-cycle start pulse to the flash controller.

The behaviour is built around a three-state machine:
- **ST_IDLE**: nothing is armed.
- **ST_ARMED**: a command is waiting for the strobe.
- **ST_FLASH**: a page erase or page write is running in the controller.

The transitions are:
- **arm**: ST_IDLE to ST_ARMED, on a valid command write.
- **re-arm**: ST_ARMED to ST_ARMED, on a valid write with no strobe in the same cycle.
- **expire**: ST_ARMED to ST_IDLE, when the window runs out.
- **fire-short**: ST_ARMED to ST_IDLE, on a strobe for a buffer store, lock set or read-section re-enable.
- **fire-long**: ST_ARMED to ST_FLASH, on a strobe for an erase or page write.
- **complete**: ST_FLASH to ST_IDLE, on `flash_done`.

The enable bit (bit 0) reads 1 in ST_ARMED and ST_FLASH. An interrupt request is raised while interrupts are enabled and no command is pending.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `irq` is 0, and no start or buffer-write pulse is active.
- R2: The read layout is: bit 7 interrupt enable, bit 6 section busy, bit 5 signature read (always 0), bits 4..1 the command (read-section re-enable, lock set, page write, page erase), bit 0 enable. Written values of bits 6 and 5 have no effect.
- R3: Only these low-five-bit patterns arm a command: 00001 buffer store, 00011 erase, 00101 page write, 01001 lock set, 10001 read-section re-enable. Any other pattern leaves bits 4..0 unchanged. Bit 7 takes the written value on every write.
- R4: A strobe is accepted in any of the ARM_CYCLES (4) clock edges after the write edge. If no strobe arrives by then, bits 4..0 read 0.
- R5: For an armed buffer store, a strobe drives `pbuf_we` in that cycle, with `word_addr` = `addr[15:1]` and `pbuf_data` = `wdata`. The enable bit reads 0 after the edge.
- R6: For an armed lock set or read-section re-enable, a strobe drives `lock_start` or `rdsec_start` for one cycle. The enable bit reads 0 after the edge.
- R7: For an armed erase or page write, a strobe drives `erase_start` or `write_start` for one cycle. The enable bit and the command bit stay 1 until `flash_done`, and bits 4..0 read 0 after that edge.
- R8: While an erase or page write is running, a register write changes only bit 7.
- R9: The section-busy bit is set by an erase or page-write start. It is cleared only when a read-section re-enable command executes.
- R10: `irq` is 1 exactly when bit 7 is 1 and bit 0 is 0.
- R11: A valid write while a command is armed replaces that command and restarts the window at ARM_CYCLES.
- R12: A strobe while nothing is armed causes no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| store_stb | input | 1 | Store instruction executing |
| addr | input | 16 | Byte address from the pointer register |
| wdata | input | 16 | Data word to store |
| flash_done | input | 1 | Controller reports erase/page-write finished |
| pbuf_we | output | 1 | Page-buffer write enable |
| word_addr | output | 15 | Word address (bit 0 of `addr` dropped) |
| pbuf_data | output | 16 | Page-buffer write data |
| erase_start | output | 1 | Page-erase start pulse |
| write_start | output | 1 | Page-write start pulse |
| lock_start | output | 1 | Lock-bit set start pulse |
| rdsec_start | output | 1 | Read-section re-enable pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: ARM_CYCLES = 4, ADDR_W = 16 and DATA_W = 16.

With a four-cycle window, the bench can aim a strobe at the last accepted edge and at the first edge after expiry. It can also re-arm mid-window and still fire on the fourth edge of the new window. The 16-bit widths let the bench check that an odd byte address maps onto the same word address as its even neighbour.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_FLASH
    } state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_BUFFER,
        OP_ERASE,
        OP_PGWRITE,
        OP_LOCK,
        OP_RDSEC
    } op_e;

    localparam int CMD_BITS = 5;
endpackage

// File: rtl/selfprog_decode.sv
module selfprog_decode
    import selfprog_pkg::*;
(
    input  logic [CMD_BITS-1:0] low_bits,
    output logic                valid,
    output op_e                 op
);
    // Exact-match decode; any other pattern is rejected (R3)
    always_comb begin
        valid = 1'b1;
        op    = OP_NONE;
        case (low_bits)
            5'b00001: op = OP_BUFFER;
            5'b00011: op = OP_ERASE;
            5'b00101: op = OP_PGWRITE;
            5'b01001: op = OP_LOCK;
            5'b10001: op = OP_RDSEC;
            default:  valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/selfprog_timer.sv
module selfprog_timer #(
    parameter int ARM_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(ARM_CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(ARM_CYCLES);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (load)
            count <= START;
        else if (count != '0)
            count <= count - 1'b1;
    end

    // The last edge of the window is reached when one cycle remains
    assign expire = (count == CW'(1));

    // R4: the counter never leaves its window range
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= START);
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int ARM_CYCLES = 4,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              store_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flash_done,
    output logic              pbuf_we,
    output logic [ADDR_W-2:0] word_addr,
    output logic [DATA_W-1:0] pbuf_data,
    output logic              erase_start,
    output logic              write_start,
    output logic              lock_start,
    output logic              rdsec_start,
    output logic              irq
);
    state_e state_q, state_nxt;
    op_e    op_q, dec_op;
    logic   dec_valid;
    logic   cmd_wr, arm_load, arm_expire, fire;
    logic   ie_q, secbusy_q;
    logic   en_bit;

    selfprog_decode u_decode (
        .low_bits (reg_wdata[CMD_BITS-1:0]),
        .valid    (dec_valid),
        .op       (dec_op)
    );

    selfprog_timer #(.ARM_CYCLES(ARM_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (arm_load),
        .expire (arm_expire)
    );

    // A command write is refused while the flash controller is working (R8)
    assign cmd_wr   = reg_we && dec_valid && (state_q != ST_FLASH);
    assign fire     = (state_q == ST_ARMED) && store_stb;
    assign arm_load = cmd_wr && !fire;

    // Next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_wr)
                    state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (store_stb) begin
                    if (op_q == OP_ERASE || op_q == OP_PGWRITE)
                        state_nxt = ST_FLASH;
                    else
                        state_nxt = ST_IDLE;
                end else if (cmd_wr) begin
                    state_nxt = ST_ARMED;
                end else if (arm_expire) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_FLASH: begin
                if (flash_done)
                    state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_nxt;
    end

    // Command, interrupt-enable and section-busy storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= OP_NONE;
            ie_q      <= 1'b0;
            secbusy_q <= 1'b0;
        end else begin
            if (arm_load)
                op_q <= dec_op;
            if (reg_we)
                ie_q <= reg_wdata[7];
            if (erase_start || write_start)
                secbusy_q <= 1'b1;
            else if (rdsec_start)
                secbusy_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        pbuf_we     = fire && (op_q == OP_BUFFER);
        erase_start = fire && (op_q == OP_ERASE);
        write_start = fire && (op_q == OP_PGWRITE);
        lock_start  = fire && (op_q == OP_LOCK);
        rdsec_start = fire && (op_q == OP_RDSEC);
        word_addr   = addr[ADDR_W-1:1];
        pbuf_data   = wdata;
        en_bit      = (state_q != ST_IDLE);
        reg_rdata   = {ie_q, secbusy_q, 1'b0,
                       en_bit && (op_q == OP_RDSEC),
                       en_bit && (op_q == OP_LOCK),
                       en_bit && (op_q == OP_PGWRITE),
                       en_bit && (op_q == OP_ERASE),
                       en_bit};
        irq         = ie_q && !en_bit;
    end

    // R4: an unanswered window closes on its last edge
    a_r4_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && arm_expire && !store_stb && !cmd_wr)
        |=> (state_q == ST_IDLE));

    // R6: at most one action pulse per cycle
    a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pbuf_we, erase_start, write_start, lock_start, rdsec_start}));

    // R7: a running erase or page write holds until the controller finishes
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLASH && !flash_done) |=> (state_q == ST_FLASH));

    // R8: the command cannot change while the flash operation runs
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLASH) |=> $stable(op_q));

    // R9: a long operation start marks the section busy
    a_r9_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start || write_start) |=> secbusy_q);

    // R12: no action leaves the block unless a command is armed
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED) |-> !(pbuf_we || erase_start || write_start
                                    || lock_start || rdsec_start));
endmodule

// File: tb/selfprog_ctrl_test.sv
`timescale 1ns/1ps
module selfprog_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        store_stb = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        flash_done = 1'b0;
    logic        pbuf_we, erase_start, write_start, lock_start, rdsec_start, irq;
    logic [14:0] word_addr;
    logic [15:0] pbuf_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    selfprog_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .store_stb(store_stb), .addr(addr), .wdata(wdata),
        .flash_done(flash_done), .pbuf_we(pbuf_we), .word_addr(word_addr),
        .pbuf_data(pbuf_data), .erase_start(erase_start), .write_start(write_start),
        .lock_start(lock_start), .rdsec_start(rdsec_start), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [4:0] pulses();
        return {pbuf_we, erase_start, write_start, lock_start, rdsec_start};
    endfunction

    // Drive a strobe for one cycle; pulses are checked before the edge
    task automatic strobe(input string tag, input logic [4:0] exp_p);
        store_stb = 1'b1;
        #1 chk(tag, pulses(), exp_p);
        @(negedge clk); store_stb = 1'b0;
    endtask

    task automatic done_pulse();
        flash_done = 1'b1;
        @(negedge clk); flash_done = 1'b0;
    endtask

    // {written byte, read right after, read after the window}
    localparam int NV = 13;
    localparam logic [23:0] VEC [NV] = '{
        24'h01_01_00, 24'h03_03_00, 24'h05_05_00, 24'h09_09_00, 24'h11_11_00,
        24'h07_00_00, 24'h0F_00_00, 24'h1F_00_00, 24'h00_00_00, 24'h61_01_00,
        24'h81_81_80, 24'h80_80_80, 24'h00_00_00
    };

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    initial begin
        idle(2);
        // R1: reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 pulses", pulses(), 5'b0);
        rst_n = 1'b1;
        idle(1);

        // R2 R3 R4: pattern table, window expiry
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][23:16]);
            chk($sformatf("R3 vec%0d armed", k), reg_rdata, VEC[k][15:8]);
            idle(4);
            chk($sformatf("R4 vec%0d expired", k), reg_rdata, VEC[k][7:0]);
        end

        // R12: strobe with nothing armed
        strobe("R12 idle strobe", 5'b0);

        // R4 R5: buffer store on the last accepted edge, odd address
        addr = 16'h1235; wdata = 16'hBEEF;
        wr(8'h01);
        idle(3);
        chk("R5 word_addr", word_addr, 15'h091A);
        chk("R5 pbuf_data", pbuf_data, 16'hBEEF);
        strobe("R4 last edge store", 5'b10000);
        chk("R5 enable cleared", reg_rdata, 8'h00);

        // R4: strobe one edge too late
        wr(8'h01);
        idle(4);
        strobe("R4 late strobe", 5'b0);

        // R7 R8 R9 R10: erase with interrupt enabled
        wr(8'h83);
        chk("R10 irq while armed", irq, 1'b0);
        strobe("R7 erase start", 5'b01000);
        chk("R9 busy set", reg_rdata, 8'hC3);
        wr(8'h05);
        chk("R8 write ignored", reg_rdata, 8'h43);
        wr(8'h83);
        idle(8);
        chk("R7 holds", reg_rdata, 8'hC3);
        done_pulse();
        chk("R7 completes", reg_rdata, 8'hC0);
        chk("R10 irq", irq, 1'b1);

        // R9: lock command leaves busy set, re-enable clears it
        wr(8'h89);
        strobe("R6 lock start", 5'b00010);
        chk("R9 busy kept", reg_rdata, 8'hC0);
        wr(8'h91);
        chk("R9 rdsec armed", reg_rdata, 8'hD1);
        strobe("R6 rdsec start", 5'b00001);
        chk("R9 busy cleared", reg_rdata, 8'h80);

        // R7: page write
        wr(8'h05);
        strobe("R7 write start", 5'b00100);
        chk("R7 write held", reg_rdata, 8'h45);
        chk("R10 irq off", irq, 1'b0);
        done_pulse();
        chk("R7 write done", reg_rdata, 8'h40);

        // R11: re-arm restarts window with new command
        wr(8'h01);
        idle(2);
        wr(8'h03);
        chk("R11 replaced", reg_rdata, 8'h43);
        idle(3);
        strobe("R11 restarted window", 5'b01000);
        done_pulse();
        chk("R11 done", reg_rdata, 8'h40);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule